// File: doc/BRIEF.md
# Compare-Match Waveform Timer Channel

This block is one 16-bit up-counting timer channel. It is controlled through a small register port. A mode register picks one of several prescaled tick inputs as the count clock. The same register chooses whether a match against the C compare value restarts the count or lets it run free, and whether that match halts the channel. It also holds the actions that the A and C compare matches apply to a single waveform output.

Each match raises a latched flag. Reading the status register returns the flags and clears them. The flags are gated by an interrupt mask, and the result drives a level interrupt. Software starts the channel with one control write that enables the count clock and restarts the count from zero. The channel then gives either a periodic event or a single one-shot event. With A=0 setting the output and C clearing it, the output is a square wave.

Top module: `tmr_channel`

Register addresses: 0 control (write: bit0 enable, bit1 disable, bit2 restart), 1 mode, 2 compare A, 3 compare C, 4 count (read), 5 status (read: bit0 A flag, bit1 C flag, bit2 running, bit3 output level), 6 mask-set (write) / mask (read), 7 mask-clear (write) / mask (read). Mode bits with four tick sources: [1:0] tick source, [2] restart on C, [3] halt on C, [5:4] A action, [7:6] C action. Action codes: 0 none, 1 drive high, 2 drive low, 3 invert. Mask bit0 is A and bit1 is C.

## Requirements
- R1: After reset the count is 0, the channel is halted, the flags, the mask, the output and the interrupt are all 0.
- R2: While running, the count rises by one on each clock edge where the selected tick input is high. Ticks on unselected inputs do nothing.
- R3: With restart-on-C set, a tick seen while the count equals C returns the count to 0, so the period is C+1 ticks.
- R4: With halt-on-C set, a tick seen while the count equals C stops the channel (running reads 0) and the count then holds.
- R5: A control write with enable and restart both set gives count 0 and a running channel on the next cycle.
- R6: A restart received while halted sets the count to 0 and leaves the channel halted.
- R7: A control write with the disable bit halts the channel, and disable wins over enable in the same write.
- R8: A C match sets status bit1. A status read returns the flags and clears them, except that a match in the same cycle as the read still sets its flag.
- R9: Writes to address 6 set mask bits and writes to address 7 clear them. Zero bits in a write leave the mask unchanged. The interrupt is high while any flag has its mask bit set.
- R10: On an A or C match the output applies that compare's action code. When both match on one tick, the C action is applied after the A action.
- R11: With restart-on-C clear, the count wraps from 0xFFFF to 0 and passes C without resetting, while the C flag is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | NSRC | Prescaled tick inputs, one selected by mode |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (status reads clear flags) |
| addr | input | 3 | Register address |
| wdata | input | W | Write data |
| rdata | output | W | Read data, combinational from addr |
| irq | output | 1 | Level interrupt |
| wave_out | output | 1 | Compare-driven waveform output |

## Verification
Every register write and every counted tick takes effect at the single clock edge that samples it. Read data is combinational, so a register read shows that edge's result on the following cycle. A status read clears its flags at the edge that ends it, and the interrupt changes at the same edge as the flag or mask. The bench drives strobes and ticks on the falling edge and holds the ticks low during register accesses. It samples half a cycle after each edge, which makes each expected count an exact tick total. The one exception is the same-cycle read-and-match check, which deliberately ticks during a read.

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int W    = 16,
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] tick,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [2:0]      addr,
  input  logic [W-1:0]    wdata,
  output logic [W-1:0]    rdata,
  output logic            irq,
  output logic            wave_out
);
  localparam int SW = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int MW = SW + 6;

  logic [W-1:0]  cnt, cmpa, cmpc;
  logic [MW-1:0] mode;
  logic          run, wave;
  logic [1:0]    flg, msk;

  logic [SW-1:0] sel;
  logic          auto_rst, stop_c;
  logic [1:0]    act_a, act_c;
  assign sel      = mode[SW-1:0];
  assign auto_rst = mode[SW];
  assign stop_c   = mode[SW+1];
  assign act_a    = mode[SW+3:SW+2];
  assign act_c    = mode[SW+5:SW+4];

  logic ctl_wr, trig, en_set, dis, adv, hit_a, hit_c, rd_stat;
  assign ctl_wr  = wr_en && addr == 3'd0;
  assign trig    = ctl_wr && wdata[2];
  assign dis     = ctl_wr && wdata[1];
  assign en_set  = ctl_wr && wdata[0];
  assign adv     = run && tick[sel] && !trig;
  assign hit_a   = adv && cnt == cmpa;
  assign hit_c   = adv && cnt == cmpc;
  assign rd_stat = rd_en && addr == 3'd5;

  function automatic logic apply_act(input logic [1:0] code, input logic v);
    case (code)
      2'd1:    return 1'b1;
      2'd2:    return 1'b0;
      2'd3:    return ~v;
      default: return v;
    endcase
  endfunction

  logic wave_a, wave_n;
  assign wave_a = hit_a ? apply_act(act_a, wave) : wave;
  assign wave_n = hit_c ? apply_act(act_c, wave_a) : wave_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      cmpa <= '0;
      cmpc <= '0;
      mode <= '0;
      run  <= 1'b0;
      wave <= 1'b0;
      flg  <= '0;
      msk  <= '0;
    end else begin
      if (trig)
        cnt <= '0;
      else if (adv)
        cnt <= (hit_c && auto_rst) ? '0 : cnt + 1'b1;

      if (dis)
        run <= 1'b0;
      else if (en_set)
        run <= 1'b1;
      else if (hit_c && stop_c)
        run <= 1'b0;

      wave <= wave_n;
      flg  <= (rd_stat ? 2'b00 : flg) | {hit_c, hit_a};

      if (wr_en) begin
        case (addr)
          3'd1: mode <= wdata[MW-1:0];
          3'd2: cmpa <= wdata;
          3'd3: cmpc <= wdata;
          3'd6: msk  <= msk | wdata[1:0];
          3'd7: msk  <= msk & ~wdata[1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      3'd1:        rdata = W'(mode);
      3'd2:        rdata = cmpa;
      3'd3:        rdata = cmpc;
      3'd4:        rdata = cnt;
      3'd5:        rdata = W'({wave, run, flg});
      3'd6, 3'd7:  rdata = W'(msk);
      default:     rdata = '0;
    endcase
  end

  assign irq      = |(flg & msk);
  assign wave_out = wave;
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk #(
  parameter int W    = 16,
  parameter int NSRC = 4,
  parameter int SW   = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] tick,
  input logic            wr_en,
  input logic [2:0]      addr,
  input logic [2:0]      ctl_bits,
  input logic [W-1:0]    cnt,
  input logic [W-1:0]    cmpc,
  input logic [SW-1:0]   sel,
  input logic            auto_rst,
  input logic            stop_c,
  input logic            run,
  input logic            flag_c
);
  logic cw, fire;
  assign cw   = wr_en && addr == 3'd0;
  assign fire = run && tick[sel] && !cw && cnt == cmpc;

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    run && tick[sel] && !cw && cnt != cmpc |=> cnt == W'($past(cnt) + 1'b1)); // R2

  AST_AUTO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    fire && auto_rst |=> cnt == '0); // R3

  AST_HALT_ON_C: assert property (@(posedge clk) disable iff (!rst_n)
    fire && stop_c |=> !run); // R4

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !cw |=> $stable(cnt)); // R4

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cw && ctl_bits[2] |=> cnt == '0); // R5

  AST_DISABLE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cw && ctl_bits[1] |=> !run); // R7

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> flag_c); // R8
endmodule

bind tmr_channel tmr_channel_chk #(.W(W), .NSRC(NSRC), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
  .ctl_bits(wdata[2:0]), .cnt(cnt), .cmpc(cmpc), .sel(sel),
  .auto_rst(auto_rst), .stop_c(stop_c), .run(run), .flag_c(flg[1])
);

// File: tb/tmr_channel_test.sv
module tmr_channel_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  tick = '0;
  logic        wr_en = 0, rd_en = 0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq, wave_out;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  tmr_channel uut (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
                   .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .wave_out(wave_out));

  always #2 clk = ~clk;

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running, expected finished");
    summary();
  end

  task automatic chk(input string r, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", r, got, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1; addr = 3'(a); wdata = 16'(d); tick = '0;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input int a, input logic [3:0] tk, output int v);
    @(negedge clk);
    rd_en = 1; addr = 3'(a); tick = tk;
    #1 v = int'(rdata);
    @(negedge clk);
    rd_en = 0; tick = '0;
  endtask

  task automatic run(input int n, input logic [3:0] t);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = t;
    end
    @(negedge clk);
    tick = '0;
  endtask

  int v;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;

    rd(4, 0, v); chk("R1 count", v, 0);
    rd(5, 0, v); chk("R1 status", v, 0);
    rd(6, 0, v); chk("R1 mask", v, 0);
    chk("R1 irq", irq, 0);
    chk("R1 wave", wave_out, 0);

    for (int c = 1; c <= 10; c++) begin
      wr(3, c); wr(1, 4); wr(0, 5);
      run(3 * c + 2, 4'b0001);
      rd(4, 0, v); chk("R3 period count", v, (3 * c + 2) % (c + 1));
      rd(5, 0, v); chk("R8 C flag after period", (v >> 1) & 1, 1);
      wr(0, 2);
    end

    wr(3, 100); wr(1, 5); wr(0, 5);
    run(5, 4'b0001); rd(4, 0, v); chk("R2 unselected ignored", v, 0);
    run(5, 4'b0010); rd(4, 0, v); chk("R2 selected counts", v, 5);
    run(3, 4'b1101); rd(4, 0, v); chk("R2 others ignored", v, 5);
    wr(0, 2);

    for (int c = 0; c <= 6; c++) begin
      wr(3, c); wr(1, 12); wr(0, 5);
      run(c, 4'b0001);
      rd(5, 0, v); chk("R4 running before match", (v >> 2) & 1, 1);
      rd(4, 0, v); chk("R4 count before match", v, c);
      run(1, 4'b0001);
      rd(5, 0, v); chk("R4 halted after match", (v >> 2) & 1, 0);
      run(3, 4'b0001);
      rd(4, 0, v); chk("R4 count holds", v, 0);
    end

    wr(3, 100); wr(1, 4); wr(0, 5);
    run(3, 4'b0001);
    wr(0, 3);
    rd(5, 0, v); chk("R7 disable wins", (v >> 2) & 1, 0);
    run(4, 4'b0001); rd(4, 0, v); chk("R7 halted count", v, 3);
    wr(0, 4);
    rd(4, 0, v); chk("R6 restart resets", v, 0);
    rd(5, 0, v); chk("R6 stays halted", (v >> 2) & 1, 0);
    run(3, 4'b0001); rd(4, 0, v); chk("R6 no counting", v, 0);
    wr(0, 1); run(2, 4'b0001);
    wr(0, 5);
    rd(4, 0, v); chk("R5 restart count", v, 0);
    rd(5, 0, v); chk("R5 running", (v >> 2) & 1, 1);
    wr(0, 2);

    wr(3, 3); wr(1, 4); rd(5, 0, v); wr(0, 5);
    run(3, 4'b0001);
    rd(5, 4'b0001, v); chk("R8 flag not yet set", (v >> 1) & 1, 0);
    rd(5, 0, v); chk("R8 same-cycle event kept", (v >> 1) & 1, 1);
    rd(5, 0, v); chk("R8 read clears", (v >> 1) & 1, 0);

    wr(7, 16'hFFFF);
    run(4, 4'b0001);
    chk("R9 masked no irq", irq, 0);
    wr(6, 2); chk("R9 irq on enable", irq, 1);
    wr(6, 0); rd(6, 0, v); chk("R9 zero write keeps mask", v, 2);
    wr(7, 1); rd(7, 0, v); chk("R9 clear other bit", v, 2);
    chk("R9 irq still high", irq, 1);
    rd(5, 0, v); chk("R9 irq drops after read", irq, 0);
    wr(7, 16'hFFFF); rd(6, 0, v); chk("R9 all masked", v, 0);
    wr(0, 2);

    wr(2, 0); wr(3, 7); wr(1, 4 | (1 << 4) | (2 << 6)); wr(0, 5);
    for (int k = 1; k <= 24; k++) begin
      run(1, 4'b0001);
      chk("R10 square wave", wave_out, (k % 8) != 0);
    end
    wr(0, 2);
    wr(3, 3); wr(1, 4 | (3 << 6)); wr(0, 5);
    for (int k = 1; k <= 16; k++) begin
      run(1, 4'b0001);
      chk("R10 toggle", wave_out, (k / 4) % 2);
    end
    wr(0, 2);
    wr(2, 2); wr(3, 2); wr(1, 4 | (2 << 4) | (1 << 6)); wr(0, 5);
    run(3, 4'b0001); chk("R10 C set wins", wave_out, 1);
    wr(0, 2);
    wr(1, 4 | (1 << 4) | (2 << 6)); wr(0, 5);
    run(3, 4'b0001); chk("R10 C clear wins", wave_out, 0);
    wr(0, 2);

    rd(5, 0, v);
    wr(3, 5); wr(1, 0); wr(0, 5);
    run(6, 4'b0001);
    rd(4, 0, v); chk("R11 passes C", v, 6);
    rd(5, 0, v); chk("R11 C flag", (v >> 1) & 1, 1);
    run(65530, 4'b0001);
    rd(4, 0, v); chk("R11 wrap to zero", v, 0);
    run(1, 4'b0001);
    rd(4, 0, v); chk("R11 after wrap", v, 1);

    summary();
  end
endmodule